// File: doc/BRIEF.md
# Compare/Capture Timer with Pulse Output

This block is a free-running up-counter with two channels. Each channel is either a compare register, whose equality with the count toggles a shared output pin, or a capture register, which records the count when its external event input rises. One 8-bit mode byte, written through a small register bus, sets the overflow behaviour, whether the pin responds to matches, the pin's active level, the channel modes and whether a channel-1 match restarts the count. A separate run bit starts and stops the timer.

Software stops the timer, writes the mode byte and the channel values, and then sets the run bit. The pin sits at its inactive level until the first compare match and then flips on every match. In overflow-halt mode the counter parks at zero after it wraps and waits for software to write the run bit again. Capture events only record the count and never move the pin.

Top module: `cmp_pulse_timer`

## Requirements
- R1: After reset the mode byte reads 0x20, the run bit reads 0, the count reads 0 and the pin is low.
- R2: The register map is: address 0 is the run bit (bit 0), address 1 the mode byte, address 2 channel 0, address 3 channel 1, and address 4 the read-only count. The mode byte holds overflow-halt in bit 7, pin enable in bit 6, active-high in bit 5, a stored external-clock flag in bit 4, clear-on-channel-1 in bit 3, and the channel 1 and channel 0 modes in bits 1 and 0 (1 = compare, 0 = capture). Bit 2 always reads 0.
- R3: A write to the mode byte while the run bit is 1 leaves the mode byte unchanged.
- R4: The count rises by one on every clock after the run bit is set. Writing 0 to the run bit clears the count to 0 and returns the pin to its inactive level.
- R5: With overflow-halt at 0 the count wraps from 0xFFFF to 0 and keeps counting.
- R6: With overflow-halt at 1 the count stays at 0 after a wrap while the run bit still reads 1. Writing 1 to the run bit starts counting again from 0.
- R7: With the pin enable at 0 the pin is held at the inactive level, which is the inverse of the active-high bit. Compare matches do not move it.
- R8: With the pin enable at 1 the pin is inactive from start until the first match. Each clock on which a compare channel equals the running count flips the pin once, and this holds even when both channels match together.
- R9: A channel in capture mode never changes the pin.
- R10: With clear-on-channel-1 set and channel 1 in compare mode, a channel-1 match makes the count 0 on the next clock instead of incrementing it.
- R11: A capture-mode channel passes its event input through two synchronizing flops. On a rising edge of the synchronized input it stores the count, which is the value two clocks after the input was first sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| cap_in | input | 2 | Asynchronous capture event inputs, one per channel |
| tmr_out | output | 1 | Timer pulse output pin |

## Verification
A table of mode bytes is run. Each entry starts the timer with chosen compare values for a fixed number of clocks and then checks the count and the pin. The entries flip the active level against the pin enable, so a wrong inactive level cannot hide behind a matching toggle count. They put one channel, two channels or neither channel in compare mode, so capture-mode gating is told apart from compare toggling. Other entries use clear-on-channel-1 with and without a second matching channel, so a wrong restart point or a double toggle shows up in both the count and the pin. Directed cases then cover the wrap in both overflow modes, the capture latency and mode writes made while the timer runs.

// File: rtl/tmr_pkg.sv
// Shared definitions for the compare/capture timer: register addresses,
// the mode byte layout and its reset value.
package tmr_pkg;
    localparam int NCH    = 2;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_RUN  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
    localparam logic [ADDR_W-1:0] A_CH0  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CH1  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;

    typedef struct packed {
        logic ovf_halt;
        logic out_en;
        logic act_high;
        logic ext_clk;
        logic clr_on_ch1;
        logic rsvd;
        logic ch1_cmp;
        logic ch0_cmp;
    } mode_t;

    localparam logic [7:0] MODE_RST  = 8'h20;
    localparam logic [7:0] RSVD_MASK = 8'h04;
endpackage

// File: rtl/tmr_regs.sv
// Run bit and mode byte. Assumes the bus writes the run bit through bit 0
// of the low byte. Mode writes are accepted only while stopped, and the
// reserved bit is forced to zero.
module tmr_regs
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              run_q,
    output logic              start_wr,
    output mode_t             mode_q
);
    logic wr_run;
    logic wr_mode;

    // Decode of the writes that target this block.
    always_comb begin
        wr_run   = wr_en && (addr == A_RUN);
        wr_mode  = wr_en && (addr == A_MODE);
        start_wr = wr_run && wdata[0];
    end

    // Run bit register.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= 1'b0;
        else if (wr_run) run_q <= wdata[0];
    end

    // Mode byte register, locked while the timer runs.
    always_ff @(posedge clk) begin
        if (!rst_n)                 mode_q <= mode_t'(MODE_RST);
        else if (wr_mode && !run_q) mode_q <= mode_t'(wdata & ~RSVD_MASK);
    end

    // R3
    mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> $stable(mode_q));
    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.rsvd == 1'b0);
endmodule

// File: rtl/tmr_counter.sv
// Up-counter with wrap or halt on overflow and a synchronous clear request.
// Assumes run is the registered run bit. A stopped timer holds the count at zero.
module tmr_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          start_wr,
    input  logic          ovf_halt,
    input  logic          clr_req,
    output logic [CW-1:0] cnt_q,
    output logic          counting
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic halted_q;

    // The count advances only while running and not parked after an overflow.
    always_comb counting = run && !halted_q;

    // Count, clear, wrap and halt sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q    <= '0;
            halted_q <= 1'b0;
        end else if (halted_q) begin
            if (start_wr) halted_q <= 1'b0;
        end else if (clr_req) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_MAX) begin
            cnt_q    <= '0;
            halted_q <= ovf_halt;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6
    halt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted_q |-> cnt_q == '0);
    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        counting && !clr_req && cnt_q != CNT_MAX |=> cnt_q == $past(cnt_q) + 1'b1);
    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        counting && clr_req |=> cnt_q == '0);
endmodule

// File: rtl/tmr_channel.sv
// One compare/capture channel: a value register, the compare match and a
// two-flop synchronizer with rising-edge detect for the capture input.
// A capture takes priority over a bus write in the same cycle.
module tmr_channel #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_mode,
    input  logic          counting,
    input  logic [CW-1:0] cnt,
    input  logic          wr_en,
    input  logic [CW-1:0] wdata,
    input  logic          cap_in,
    output logic [CW-1:0] val_q,
    output logic          match
);
    logic [2:0] sync_q;
    logic       rise;

    // Synchronizer and edge-history chain for the event input.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], cap_in};
    end

    // Match and capture-edge decode.
    always_comb begin
        rise  = sync_q[1] && !sync_q[2];
        match = cmp_mode && counting && (cnt == val_q);
    end

    // Channel value: captured count or bus-written value.
    always_ff @(posedge clk) begin
        if (!rst_n)                 val_q <= '0;
        else if (!cmp_mode && rise) val_q <= cnt;
        else if (wr_en)             val_q <= wdata;
    end

    // R11
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_mode && rise |=> val_q == $past(cnt));
endmodule

// File: rtl/tmr_outpin.sv
// Output pin state. Keeps an "active" flag that is cleared while stopped
// or disabled and flips once per clock on which any compare channel matches.
// The pin level is the flag mapped through the active-level bit.
module tmr_outpin #(
    parameter int NM = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          out_en,
    input  logic          act_high,
    input  logic [NM-1:0] match,
    output logic          pin
);
    logic active_q;

    // Active flag: cleared when stopped or disabled, flipped on any match.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !out_en) active_q <= 1'b0;
        else if (|match)               active_q <= !active_q;
    end

    // Pin level from the flag and the polarity bit.
    always_comb pin = act_high ? active_q : !active_q;

    // R7
    disabled_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> pin == !act_high);
    // R8
    no_spurious_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && out_en && !(|match) |=> $stable(pin));
    // R4
    stop_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> pin == !act_high);
endmodule

// File: rtl/cmp_pulse_timer.sv
// Top of the compare/capture timer. Wires the registers, the counter, two
// channels and the pin logic, and drives the combinational read mux.
// Assumes CW >= 8 so the mode byte fits in the data bus.
module cmp_pulse_timer
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CW-1:0]     reg_wdata,
    output logic [CW-1:0]     reg_rdata,
    input  logic [NCH-1:0]    cap_in,
    output logic              tmr_out
);
    logic           run_q;
    logic           start_wr;
    mode_t          mode_q;
    logic [CW-1:0]  cnt_q;
    logic           counting;
    logic [NCH-1:0] match;
    logic [NCH-1:0] cmp_sel;
    logic [CW-1:0]  ch_val [NCH];

    // Per-channel mode bits from the mode byte.
    always_comb cmp_sel = {mode_q.ch1_cmp, mode_q.ch0_cmp};

    tmr_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata[7:0]),
        .run_q    (run_q),
        .start_wr (start_wr),
        .mode_q   (mode_q)
    );

    tmr_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .start_wr (start_wr),
        .ovf_halt (mode_q.ovf_halt),
        .clr_req  (mode_q.clr_on_ch1 && match[1]),
        .cnt_q    (cnt_q),
        .counting (counting)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_channel #(.CW(CW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmp_mode (cmp_sel[g]),
            .counting (counting),
            .cnt      (cnt_q),
            .wr_en    (reg_wr && (reg_addr == A_CH0 + ADDR_W'(g))),
            .wdata    (reg_wdata),
            .cap_in   (cap_in[g]),
            .val_q    (ch_val[g]),
            .match    (match[g])
        );
    end

    tmr_outpin #(.NM(NCH)) u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .out_en   (mode_q.out_en),
        .act_high (mode_q.act_high),
        .match    (match),
        .pin      (tmr_out)
    );

    // Read data selection by address.
    always_comb begin
        case (reg_addr)
            A_RUN:   reg_rdata = CW'(run_q);
            A_MODE:  reg_rdata = CW'(mode_q);
            A_CH0:   reg_rdata = ch_val[0];
            A_CH1:   reg_rdata = ch_val[1];
            A_CNT:   reg_rdata = cnt_q;
            default: reg_rdata = '0;
        endcase
    end

    // R9
    capture_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q.ch0_cmp && !mode_q.ch1_cmp |-> match == '0);
endmodule

// File: tb/cmp_pulse_timer_test.sv
`timescale 1ns/1ps
module cmp_pulse_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [1:0]  cap_in = 2'b00;
    logic        tmr_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cmp_pulse_timer uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in),
        .tmr_out(tmr_out)
    );

    // mode, ch0, ch1, clocks, expected pin, expected count
    localparam int NV = 8;
    localparam logic [64:0] VEC [NV] = '{
        {8'h63, 16'd5,   16'd100, 8'd10, 1'b1, 16'd10},  // R8 one compare match, active high
        {8'h43, 16'd5,   16'd7,   8'd10, 1'b1, 16'd10},  // R8 two matches, active low
        {8'h23, 16'd5,   16'd7,   8'd10, 1'b0, 16'd10},  // R7 disabled, active high
        {8'h03, 16'd5,   16'd7,   8'd10, 1'b1, 16'd10},  // R7 disabled, active low
        {8'h60, 16'd5,   16'd7,   8'd10, 1'b0, 16'd10},  // R9 both capture
        {8'h6B, 16'd200, 16'd3,   8'd10, 1'b0, 16'd2},   // R10 clear on ch1
        {8'h62, 16'd4,   16'd4,   8'd10, 1'b1, 16'd10},  // R9 ch0 capture, ch1 compare
        {8'h6B, 16'd1,   16'd3,   8'd10, 1'b1, 16'd2}    // R10 clear plus ch0 matches
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d, output logic p);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata; p = tmr_out;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        logic p;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(3'd1, d, p); check("R1 mode", d, 16'h20);
        rd(3'd0, d, p); check("R1 run", d, 0);
        rd(3'd4, d, p); check("R1 count", d, 0);
        check("R1 pin", p, 0);

        // Table of mode/compare vectors
        for (int i = 0; i < NV; i++) begin
            wr(3'd0, 16'd0);
            wr(3'd1, {8'h00, VEC[i][64:57]});
            wr(3'd2, VEC[i][56:41]);
            wr(3'd3, VEC[i][40:25]);
            wr(3'd0, 16'd1);
            repeat (int'(VEC[i][24:17])) @(posedge clk);
            rd(3'd4, d, p);
            check($sformatf("R8 vec%0d pin", i), p, VEC[i][16]);
            check($sformatf("R4 vec%0d count", i), d, VEC[i][15:0]);
        end

        // R4 stop clears count and restores inactive level (mode 0x6B, active high)
        wr(3'd0, 16'd0);
        rd(3'd4, d, p);
        check("R4 stop count", d, 0);
        check("R4 stop pin", p, 0);

        // R2 reserved bit reads zero
        wr(3'd1, 16'h00FF);
        rd(3'd1, d, p); check("R2 mode readback", d, 16'hFB);

        // R11 capture latency, R3 locked mode, R9 pin unaffected
        wr(3'd1, 16'h0060);
        wr(3'd0, 16'd1);
        repeat (9) @(posedge clk);
        @(negedge clk) cap_in[0] = 1'b1;
        repeat (5) @(posedge clk);
        rd(3'd2, d, p);
        check("R11 captured count", d, 11);
        check("R9 pin after capture", p, 0);
        wr(3'd1, 16'h0003);
        rd(3'd1, d, p); check("R3 mode locked", d, 16'h60);
        cap_in[0] = 1'b0;

        // R6 overflow halt and restart
        wr(3'd0, 16'd0);
        wr(3'd1, 16'h00A0);
        wr(3'd0, 16'd1);
        repeat (65541) @(posedge clk);
        rd(3'd4, d, p); check("R6 parked count", d, 0);
        rd(3'd0, d, p); check("R6 run still set", d, 1);
        wr(3'd0, 16'd1);
        repeat (3) @(posedge clk);
        rd(3'd4, d, p); check("R6 restart count", d, 3);

        // R5 free-running wrap
        wr(3'd0, 16'd0);
        wr(3'd1, 16'h0020);
        wr(3'd0, 16'd1);
        repeat (65539) @(posedge clk);
        rd(3'd4, d, p); check("R5 wrapped count", d, 3);

        finish_run();
    end
endmodule